// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A single-clock, synthesizable SRAM model holding 36-bit words split into four 9-bit byte lanes, with a parameterised address width (20 bits at full size, smaller by default for simulation). All address, data, select, strobe and write-enable pins are taken on the rising clock edge. An access sequence is opened by one of two active-low address strobes: a host strobe, which always performs a read and is honoured only while the primary select is low, and a control strobe, which takes the write enables in the same cycle. After the opening cycle, an internal 2-bit counter steps the low two address bits whenever the advance pin is low. The burst order is either linear or interleaved, picked by a static order pin.

Read data flows out as a stream with a valid flag. It passes through a read stage and then an output register, so it appears two edges after the cycle that captured the access. The data path has no ready input, so there is no back-pressure. A consumer must accept each word in the cycle `rvalid_o` is high, because the next access overwrites the output register. The output-enable pin only masks the valid flag. A sleep pin freezes all accesses and all burst state.

Top module: `burst_sram`

## Requirements
- R1: An access is performed only when `sel_n_i`=0, `sel_hi_i`=1 and `sel2_n_i`=0 together. A strobe cycle with any of the three not asserted writes nothing, reads nothing, and ends the current burst, so later advance cycles make no access.
- R2: While `sel_n_i`=1, a low `host_strobe_n_i` is ignored. A cycle opened by `host_strobe_n_i` with the chip selected is always a read, whatever the write enables are.
- R3: A cycle opened by `ctl_strobe_n_i` (with `host_strobe_n_i` high) takes the write enables in that same cycle. Continuation cycles of a burst also take the write enables.
- R4: With `byte_wr_n_i`=0, each lane i whose `lane_en_n_i[i]`=0 writes data bits [9i+8:9i], and the other lanes keep their contents. With `byte_wr_n_i`=1, `lane_en_n_i` has no effect.
- R5: `all_wr_n_i`=0 writes all 36 bits, regardless of `byte_wr_n_i` and `lane_en_n_i`.
- R6: With `order_i`=0 (linear), the k-th access of a burst uses low bits (start+k) mod 4. The upper address bits never change during a burst.
- R7: With `order_i`=1 (interleaved), the k-th access uses low bits start XOR k.
- R8: A cycle with both strobes and `adv_n_i` high, inside a burst, repeats the access at the current address.
- R9: Read data of an access taken at edge n is on `rdata_o`, with `rvalid_o`=1, after edge n+1.
- R10: `oe_n_i`=1 forces `rvalid_o` low. It leaves `rdata_o` and the pipeline contents unchanged.
- R11: While `sleep_i`=1, no read or write happens, and the memory contents and burst position are kept. After wake-up, an advance resumes from the same position.
- R12: After reset, `rvalid_o` is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of control state |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| sel_n_i | input | 1 | Primary select, active low, also gates the host strobe |
| sel_hi_i | input | 1 | Secondary select, active high |
| sel2_n_i | input | 1 | Tertiary select, active low |
| host_strobe_n_i | input | 1 | Host address strobe, active low, read-only start |
| ctl_strobe_n_i | input | 1 | Control address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| byte_wr_n_i | input | 1 | Byte-write master enable, active low |
| lane_en_n_i | input | 4 | Per-lane write enables, active low |
| all_wr_n_i | input | 1 | Global write of all lanes, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep_i | input | 1 | Sleep: freezes accesses and burst state |
| oe_n_i | input | 1 | Output enable, active low, masks `rvalid_o` |
| rdata_o | output | 36 | Read data stream |
| rvalid_o | output | 1 | Read data valid |

## Verification
On every cycle, the embedded properties check the following:
- host-strobe starts never write;
- deselected strobes produce no output two edges later;
- sleep blocks every access and keeps the burst state;
- every read reaches the output register after exactly two edges;
- output enable masks the valid flag;
- the upper address bits hold still inside a burst.

Only the directed scenarios can show the actual data values. These scenarios cover the linear and interleaved address sequences, lane merging under byte writes, global-write override, held-address repeats, and memory contents surviving ignored writes during sleep or deselect.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int BURST_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  // low address bits for the k-th beat of a burst that started at 'start'
  function automatic logic [BURST_W-1:0] burst_low(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] beat,
    input burst_order_e       order
  );
    return (order == ORD_INTERLEAVE) ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  burst_order_e      order_i,
  output logic [ADDR_W-1:0] acc_addr_o
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] beat_q;
  logic [BURST_W-1:0] beat_inc;
  logic [BURST_W-1:0] beat_use;

  assign beat_inc = beat_q + 1'b1;
  assign beat_use = step_i ? beat_inc : beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load_i) begin
      base_q <= ext_addr_i;
      beat_q <= '0;
    end else if (step_i) begin
      beat_q <= beat_inc;
    end
  end

  assign acc_addr_o = load_i ? ext_addr_i :
    {base_q[ADDR_W-1:BURST_W], burst_low(base_q[BURST_W-1:0], beat_use, order_i)};

  // R6: upper bits of the burst base only change on a new load
  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(base_q[ADDR_W-1:BURST_W]));
endmodule

// File: rtl/burst_lane_mem.sv
module burst_lane_mem #(
  parameter int ADDR_W  = 8,
  parameter int LANE_W  = 9,
  parameter int N_LANES = 4
) (
  input  logic                      clk,
  input  logic [N_LANES-1:0]        we_i,
  input  logic                      re_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [N_LANES*LANE_W-1:0] wdata_i,
  output logic [N_LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
      if (re_i)    rd_q        <= mem[addr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANE_W  = 9,
  parameter int N_LANES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [N_LANES*LANE_W-1:0] wdata_i,
  input  logic                      sel_n_i,
  input  logic                      sel_hi_i,
  input  logic                      sel2_n_i,
  input  logic                      host_strobe_n_i,
  input  logic                      ctl_strobe_n_i,
  input  logic                      adv_n_i,
  input  logic                      byte_wr_n_i,
  input  logic [N_LANES-1:0]        lane_en_n_i,
  input  logic                      all_wr_n_i,
  input  logic                      order_i,
  input  logic                      sleep_i,
  input  logic                      oe_n_i,
  output logic [N_LANES*LANE_W-1:0] rdata_o,
  output logic                      rvalid_o
);
  localparam int DATA_W = N_LANES * LANE_W;

  logic selected, host_start, ctl_start, new_cyc, awake;
  logic load, kill, cont, step, access, rd_fire;
  logic active_q;
  logic [N_LANES-1:0] lane_we;
  logic [ADDR_W-1:0]  acc_addr;
  logic [DATA_W-1:0]  mem_rd;
  logic               rd_v_q, out_v_q;
  logic [DATA_W-1:0]  out_q;

  assign selected   = !sel_n_i && sel_hi_i && !sel2_n_i;
  assign host_start = !host_strobe_n_i && !sel_n_i;
  assign ctl_start  = !ctl_strobe_n_i && !host_start;
  assign new_cyc    = host_start || ctl_start;
  assign awake      = !sleep_i;

  assign load   = awake && new_cyc && selected;
  assign kill   = awake && new_cyc && !selected;
  assign cont   = awake && !new_cyc && active_q;
  assign step   = cont && !adv_n_i;
  assign access = load || cont;

  for (genvar l = 0; l < N_LANES; l++) begin : g_we
    assign lane_we[l] = access && !host_start &&
                        (!all_wr_n_i || (!byte_wr_n_i && !lane_en_n_i[l]));
  end

  assign rd_fire = access && (lane_we == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    active_q <= 1'b0;
    else if (load) active_q <= 1'b1;
    else if (kill) active_q <= 1'b0;
  end

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .step_i    (step),
    .ext_addr_i(addr_i),
    .order_i   (burst_order_e'(order_i)),
    .acc_addr_o(acc_addr)
  );

  burst_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .N_LANES(N_LANES)) u_mem (
    .clk    (clk),
    .we_i   (lane_we),
    .re_i   (rd_fire),
    .addr_i (acc_addr),
    .wdata_i(wdata_i),
    .rdata_o(mem_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_v_q  <= 1'b0;
      out_v_q <= 1'b0;
      out_q   <= '0;
    end else begin
      rd_v_q  <= rd_fire;
      out_v_q <= rd_v_q;
      if (rd_v_q) out_q <= mem_rd;
    end
  end

  assign rdata_o  = out_q;
  assign rvalid_o = out_v_q && !oe_n_i;

  // R1: a deselecting strobe yields no read output through the pipeline
  a_r1_deselect_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && new_cyc && !selected) |-> ##2 !out_v_q);
  // R2: a host-strobe start never writes
  a_r2_host_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (host_start && selected) |-> (lane_we == '0));
  // R9: every read reaches the output register two edges later
  a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> ##2 out_v_q);
  // R10: output enable high masks valid
  a_r10_oe_mask: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !rvalid_o);
  // R11: sleep blocks accesses and keeps burst state
  a_r11_sleep_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> (lane_we == '0) && !rd_fire);
  a_r11_sleep_keeps_burst: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> $stable(active_q));
endmodule

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
  localparam int AW = 8;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic sel_n, sel_hi, sel2_n, host_n, ctl_n, adv_n, byte_wr_n, all_wr_n, order, sleep, oe_n;
  logic [3:0] lane_en_n;
  logic [DW-1:0] rdata;
  logic rvalid;

  logic [DW-1:0] shadow [1<<AW];
  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  burst_sram #(.ADDR_W(AW)) u_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .sel_n_i(sel_n), .sel_hi_i(sel_hi), .sel2_n_i(sel2_n),
    .host_strobe_n_i(host_n), .ctl_strobe_n_i(ctl_n), .adv_n_i(adv_n),
    .byte_wr_n_i(byte_wr_n), .lane_en_n_i(lane_en_n), .all_wr_n_i(all_wr_n),
    .order_i(order), .sleep_i(sleep), .oe_n_i(oe_n),
    .rdata_o(rdata), .rvalid_o(rvalid)
  );

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'(a * 36'h0_2468_ACE + salt * 36'h1_1111_111) ^ 36'h5_A5A5_A5A5;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // deselecting control-strobe cycle: ends any burst, no access
  task automatic set_idle();
    addr = '0; wdata = '0;
    sel_n = 1'b1; sel_hi = 1'b1; sel2_n = 1'b0;
    host_n = 1'b1; ctl_n = 1'b0; adv_n = 1'b1;
    byte_wr_n = 1'b1; lane_en_n = 4'hF; all_wr_n = 1'b1;
    sleep = 1'b0; oe_n = 1'b0;
  endtask

  task automatic select_on();
    sel_n = 1'b0; sel_hi = 1'b1; sel2_n = 1'b0;
  endtask

  task automatic burst_cont(input logic adv);
    host_n = 1'b1; ctl_n = 1'b1; adv_n = adv;
    all_wr_n = 1'b1; byte_wr_n = 1'b1; lane_en_n = 4'hF;
  endtask

  task automatic write_word(input int a, input logic [DW-1:0] d);
    select_on(); ctl_n = 1'b0; host_n = 1'b1; addr = AW'(a); wdata = d; all_wr_n = 1'b0;
    tick();
    set_idle(); tick();
    shadow[a] = d;
  endtask

  task automatic read_check(input int a, input string tag);
    select_on(); host_n = 1'b0; ctl_n = 1'b1; addr = AW'(a);
    tick();
    set_idle(); tick();
    chk({tag, " valid"}, DW'(rvalid), DW'(1));
    chk({tag, " data"}, rdata, shadow[a]);
  endtask

  task automatic t_reset();
    chk("R12 rvalid after reset", DW'(rvalid), DW'(0));
    set_idle(); adv_n = 1'b0; ctl_n = 1'b1; tick(); tick();
    chk("R12 no burst after reset", DW'(rvalid), DW'(0));
    set_idle(); tick();
  endtask

  task automatic t_latency();
    write_word(8'h05, pat(5, 1));
    select_on(); host_n = 1'b0; ctl_n = 1'b1; addr = 8'h05;
    tick();
    chk("R9 not valid after first edge", DW'(rvalid), DW'(0));
    set_idle(); tick();
    chk("R9 valid after second edge", DW'(rvalid), DW'(1));
    chk("R9 data", rdata, pat(5, 1));
    chk("R5 global write data", rdata, shadow[8'h05]);
    tick();
    chk("R9 single word only", DW'(rvalid), DW'(0));
  endtask

  task automatic t_burst_read(input int start, input logic ord, input string tag);
    for (int i = 0; i < 4; i++) write_word((start & ~3) + i, pat((start & ~3) + i, 7));
    order = ord;
    select_on(); host_n = 1'b0; ctl_n = 1'b1; addr = AW'(start);
    tick();
    for (int k = 0; k < 4; k++) begin
      int lo, a;
      lo = ord ? ((start & 3) ^ k) : (((start & 3) + k) & 3);
      a = (start & ~3) | lo;
      if (k < 3) burst_cont(1'b0); else set_idle();
      order = ord;
      tick();
      chk({tag, " beat valid"}, DW'(rvalid), DW'(1));
      chk({tag, " beat data"}, rdata, shadow[a]);
    end
    order = 1'b0;
  endtask

  task automatic t_hold();
    for (int i = 0; i < 4; i++) write_word(8'h20 + i, pat(8'h20 + i, 3));
    select_on(); host_n = 1'b0; ctl_n = 1'b1; addr = 8'h21;
    tick();
    burst_cont(1'b1); tick();
    chk("R8 first", rdata, shadow[8'h21]);
    tick();
    chk("R8 repeat", rdata, shadow[8'h21]);
    chk("R8 repeat valid", DW'(rvalid), DW'(1));
    burst_cont(1'b0); tick();
    chk("R8 still held", rdata, shadow[8'h21]);
    set_idle(); tick();
    chk("R8 advance after hold", rdata, shadow[8'h22]);
  endtask

  task automatic t_oe();
    for (int i = 0; i < 4; i++) write_word(8'h30 + i, pat(8'h30 + i, 4));
    select_on(); host_n = 1'b0; ctl_n = 1'b1; addr = 8'h30;
    tick();
    burst_cont(1'b0); oe_n = 1'b1; tick();
    chk("R10 masked valid", DW'(rvalid), DW'(0));
    chk("R10 data kept", rdata, shadow[8'h30]);
    oe_n = 1'b0; #1;
    chk("R10 unmasked", DW'(rvalid), DW'(1));
    tick();
    chk("R10 pipeline intact", rdata, shadow[8'h31]);
    set_idle(); tick(); tick();
  endtask

  task automatic t_burst_write();
    select_on(); ctl_n = 1'b0; host_n = 1'b1; addr = 8'h42; all_wr_n = 1'b0;
    wdata = pat(0, 9);
    tick();
    for (int k = 1; k < 4; k++) begin
      host_n = 1'b1; ctl_n = 1'b1; adv_n = 1'b0; all_wr_n = 1'b0;
      wdata = pat(k, 9);
      tick();
    end
    set_idle(); tick();
    for (int k = 0; k < 4; k++) shadow[8'h40 + ((2 + k) & 3)] = pat(k, 9);
    for (int k = 0; k < 4; k++) read_check(8'h40 + k, "R3 burst write readback");
  endtask

  task automatic t_lanes();
    logic [DW-1:0] a_val, b_val, exp;
    a_val = 36'hF_FFFF_FFFF; b_val = 36'h1_2345_6789;
    write_word(8'h50, a_val);
    select_on(); ctl_n = 1'b0; addr = 8'h50; wdata = b_val;
    byte_wr_n = 1'b0; lane_en_n = 4'b1010;
    tick(); set_idle(); tick();
    exp = a_val;
    exp[8:0] = b_val[8:0];
    exp[26:18] = b_val[26:18];
    shadow[8'h50] = exp;
    read_check(8'h50, "R4 lanes 0 and 2");
    select_on(); ctl_n = 1'b0; addr = 8'h50; wdata = 36'h0;
    byte_wr_n = 1'b1; lane_en_n = 4'h0;
    tick(); set_idle(); tick();
    read_check(8'h50, "R4 lane enables ignored");
    select_on(); ctl_n = 1'b0; addr = 8'h50; wdata = 36'h9_8765_4321;
    all_wr_n = 1'b0; byte_wr_n = 1'b1; lane_en_n = 4'hF;
    tick(); set_idle(); tick();
    shadow[8'h50] = 36'h9_8765_4321;
    read_check(8'h50, "R5 global write overrides");
  endtask

  task automatic t_select();
    write_word(8'h60, pat(6, 6));
    for (int s = 0; s < 3; s++) begin
      select_on();
      if (s == 0) sel_n = 1'b1;
      if (s == 1) sel_hi = 1'b0;
      if (s == 2) sel2_n = 1'b1;
      ctl_n = 1'b0; addr = 8'h60; wdata = 36'h0; all_wr_n = 1'b0;
      tick(); set_idle(); tick();
      chk("R1 no read output", DW'(rvalid), DW'(0));
      read_check(8'h60, "R1 write blocked");
    end
    select_on(); host_n = 1'b0; ctl_n = 1'b1; addr = 8'h60; tick();
    select_on(); sel_hi = 1'b0; ctl_n = 1'b0; host_n = 1'b1; tick();
    burst_cont(1'b0); tick(); tick();
    chk("R1 burst ended by deselect", DW'(rvalid), DW'(0));
    set_idle(); tick();
  endtask

  task automatic t_host();
    write_word(8'h66, pat(66, 2));
    sel_n = 1'b1; sel_hi = 1'b1; sel2_n = 1'b0;
    host_n = 1'b0; ctl_n = 1'b1; addr = 8'h66;
    tick(); burst_cont(1'b1); tick(); tick();
    chk("R2 host strobe ignored", DW'(rvalid), DW'(0));
    set_idle(); tick();
    select_on(); host_n = 1'b0; ctl_n = 1'b1; addr = 8'h66;
    all_wr_n = 1'b0; wdata = 36'h0;
    tick(); set_idle(); tick();
    chk("R2 host start reads", rdata, shadow[8'h66]);
    read_check(8'h66, "R2 host start no write");
  endtask

  task automatic t_sleep();
    for (int i = 0; i < 4; i++) write_word(8'h70 + i, pat(8'h70 + i, 5));
    write_word(8'h74, pat(8'h74, 5));
    select_on(); host_n = 1'b0; ctl_n = 1'b1; addr = 8'h70;
    tick();
    sleep = 1'b1; host_n = 1'b1; ctl_n = 1'b0; addr = 8'h74; wdata = 36'h0; all_wr_n = 1'b0;
    tick();
    chk("R11 prior read drains", rdata, shadow[8'h70]);
    ctl_n = 1'b1; all_wr_n = 1'b1; adv_n = 1'b0;
    tick();
    chk("R11 no read in sleep", DW'(rvalid), DW'(0));
    sleep = 1'b0; adv_n = 1'b0;
    tick();
    set_idle(); tick();
    chk("R11 resume position", rdata, shadow[8'h71]);
    chk("R11 resume valid", DW'(rvalid), DW'(1));
    read_check(8'h74, "R11 contents kept");
  endtask

  initial begin
    set_idle(); order = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_latency();
    t_burst_read(8'h12, 1'b0, "R6 linear");
    t_burst_read(8'h1D, 1'b1, "R7 interleaved");
    t_hold();
    t_oe();
    t_burst_write();
    t_lanes();
    t_select();
    t_host();
    t_sleep();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule